// File: doc/BRIEF.md
# Transmit Lane Deskew Calibrator

This block sits between the fabric and a group of parallel serial transmit lanes. Word-clock phase differences between lanes can leave up to one parallel word of skew at the far end. The block corrects that skew on the transmit side. Every lane's word passes through a two-register pipeline. An output selector takes the word straight through, after one register, or after both, so each lane can add zero, one or two words of delay.

A pulse on `start` begins calibration. All lanes then carry the same incrementing training word. A search engine works through every per-lane delay combination in a fixed order. After each change it waits a programmable number of cycles and then samples the per-lane aligned flags returned by the receiver. The first combination that aligns all lanes is locked, and the lanes switch to user data. If no combination aligns, the block raises `fail` and goes back to idle. The skew does not change after power-up, so the chosen settings are held with no further tracking.

Top module: `tx_deskew_cal`

## Requirements
- R1: After reset, `busy`, `done` and `fail` are low and every field of `lane_delay` is zero.
- R2: Lane i uses the field `lane_delay[2i+1:2i]`. Value 0 bypasses both registers, 1 adds one word and 2 adds two words. The lane's `tx_data` slice equals that lane's input word from that many cycles earlier. Value 3 never occurs.
- R3: While the block is not locked, every lane's input is the same training word, and that word increases by one each cycle (wrapping at 2^WIDTH).
- R4: A search starts with all fields at zero and advances like a base-3 counter, with lane 0 as the least significant digit.
- R5: Each combination is held for exactly `settle_cycles`+1 cycles, and `lane_aligned` is sampled at the last edge of that window. A search that locks on the k-th combination (counting from 1) keeps `busy` high for k*(`settle_cycles`+1) cycles.
- R6: The first combination that reports all lanes aligned is locked. `done` goes high, `busy` goes low, `lane_delay` holds, and every lane carries `user_data` through its chosen delay.
- R7: If no combination in all 3^LANES reports full alignment, `fail` goes high, `busy` goes low after 3^LANES*(`settle_cycles`+1) busy cycles, and `lane_delay` returns to zero.
- R8: A `start` pulse during a search has no effect on the search order or its length.
- R9: A `start` pulse while idle, locked or failed clears `done` and `fail` and begins a new search from all zero.
- R10: `lane_delay` changes only at clock edges and stays constant for as long as `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a calibration when not searching |
| settle_cycles | input | SETTLE_W | Extra wait cycles after each setting change |
| user_data | input | LANES*WIDTH | Fabric words, lane 0 in the low bits |
| lane_aligned | input | LANES | Per-lane aligned reports from the receiver |
| tx_data | output | LANES*WIDTH | Words to the serializers, lane 0 in the low bits |
| lane_delay | output | 2*LANES | Current delay setting, two bits per lane |
| busy | output | 1 | Search in progress |
| done | output | 1 | Settings locked, user data flowing |
| fail | output | 1 | Last search found no aligned combination |

## Verification
A wrong digit, carry or settle count in the search engine changes the locked `lane_delay` or the busy length. The bench compares both against an independent model at the cycle `done` or `fail` rises, so the error shows at the end of that search. A wrong selector or stage register in a lane changes that lane's `tx_data` within two cycles of a new user word. The bench checks it against a history of the words it drove. A broken training counter shows in the first cycle of any search, because the lanes then disagree or the word fails to step by one.

// File: rtl/tx_deskew_pkg.sv
package tx_deskew_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SEARCH = 2'd1,
        ST_LOCK   = 2'd2
    } cal_state_e;

    localparam logic [1:0] DLY_NONE = 2'd0;
    localparam logic [1:0] DLY_ONE  = 2'd1;
    localparam logic [1:0] DLY_TWO  = 2'd2;

endpackage

// File: rtl/tdc_lane_delay.sv
module tdc_lane_delay #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       sel,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    import tx_deskew_pkg::*;

    typedef struct packed {
        logic [WIDTH-1:0] st1;
        logic [WIDTH-1:0] st2;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    always_comb begin
        pipe_d     = pipe_q;
        pipe_d.st1 = din;
        pipe_d.st2 = pipe_q.st1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    // sel comes from a register, so the selector only moves at an edge
    always_comb begin
        case (sel)
            DLY_ONE: dout = pipe_q.st1;
            DLY_TWO: dout = pipe_q.st2;
            default: dout = din;
        endcase
    end
endmodule

// File: rtl/tdc_train_gen.sv
module tdc_train_gen #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [WIDTH-1:0] pattern
);
    logic [WIDTH-1:0] seq_d, seq_q;

    always_comb seq_d = seq_q + WIDTH'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign pattern = seq_q;
endmodule

// File: rtl/tdc_search_fsm.sv
module tdc_search_fsm #(
    parameter int LANES    = 4,
    parameter int SETTLE_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic [SETTLE_W-1:0]       settle_cycles,
    input  logic [LANES-1:0]          lane_aligned,
    output logic [LANES-1:0][1:0]     delay_sel,
    output logic                      busy,
    output logic                      done,
    output logic                      fail
);
    import tx_deskew_pkg::*;

    typedef struct packed {
        cal_state_e             state;
        logic [SETTLE_W-1:0]    wait_cnt;
        logic [LANES-1:0][1:0]  digit;
        logic                   failed;
    } fsm_t;

    fsm_t fsm_d, fsm_q;
    logic at_last;
    logic carry;

    always_comb begin
        at_last = 1'b1;
        for (int i = 0; i < LANES; i++) begin
            if (fsm_q.digit[i] != DLY_TWO) at_last = 1'b0;
        end
    end

    always_comb begin
        fsm_d = fsm_q;
        carry = 1'b0;
        case (fsm_q.state)
            ST_SEARCH: begin
                if (fsm_q.wait_cnt != '0) begin
                    fsm_d.wait_cnt = fsm_q.wait_cnt - SETTLE_W'(1);
                end else if (&lane_aligned) begin
                    fsm_d.state = ST_LOCK;
                end else if (at_last) begin
                    fsm_d.state  = ST_IDLE;
                    fsm_d.failed = 1'b1;
                    fsm_d.digit  = '0;
                end else begin
                    carry = 1'b1;
                    for (int i = 0; i < LANES; i++) begin
                        if (carry) begin
                            if (fsm_q.digit[i] == DLY_TWO) begin
                                fsm_d.digit[i] = DLY_NONE;
                            end else begin
                                fsm_d.digit[i] = fsm_q.digit[i] + 2'd1;
                                carry          = 1'b0;
                            end
                        end
                    end
                    fsm_d.wait_cnt = settle_cycles;
                end
            end
            default: begin
                if (start) begin
                    fsm_d.state    = ST_SEARCH;
                    fsm_d.wait_cnt = settle_cycles;
                    fsm_d.digit    = '0;
                    fsm_d.failed   = 1'b0;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q.state    <= ST_IDLE;
            fsm_q.wait_cnt <= '0;
            fsm_q.digit    <= '0;
            fsm_q.failed   <= 1'b0;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign delay_sel = fsm_q.digit;
    assign busy      = (fsm_q.state == ST_SEARCH);
    assign done      = (fsm_q.state == ST_LOCK);
    assign fail      = fsm_q.failed;
endmodule

// File: rtl/tx_deskew_cal.sv
module tx_deskew_cal #(
    parameter int LANES    = 4,
    parameter int WIDTH    = 32,
    parameter int SETTLE_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [SETTLE_W-1:0]    settle_cycles,
    input  logic [LANES*WIDTH-1:0] user_data,
    input  logic [LANES-1:0]       lane_aligned,
    output logic [LANES*WIDTH-1:0] tx_data,
    output logic [2*LANES-1:0]     lane_delay,
    output logic                   busy,
    output logic                   done,
    output logic                   fail
);
    logic [WIDTH-1:0]          train_word;
    logic [LANES-1:0][1:0]     sel;

    tdc_train_gen #(.WIDTH(WIDTH)) u_train (
        .clk     (clk),
        .rst_n   (rst_n),
        .pattern (train_word)
    );

    tdc_search_fsm #(.LANES(LANES), .SETTLE_W(SETTLE_W)) u_search (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start),
        .settle_cycles (settle_cycles),
        .lane_aligned  (lane_aligned),
        .delay_sel     (sel),
        .busy          (busy),
        .done          (done),
        .fail          (fail)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [WIDTH-1:0] lane_in;
        assign lane_in = done ? user_data[g*WIDTH +: WIDTH] : train_word;

        tdc_lane_delay #(.WIDTH(WIDTH)) u_dly (
            .clk   (clk),
            .rst_n (rst_n),
            .sel   (sel[g]),
            .din   (lane_in),
            .dout  (tx_data[g*WIDTH +: WIDTH])
        );

        assign lane_delay[2*g +: 2] = sel[g];
    end
endmodule

// File: rtl/tx_deskew_cal_chk.sv
module tx_deskew_cal_chk #(
    parameter int LANES = 4,
    parameter int WIDTH = 32
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   start,
    input logic [LANES*WIDTH-1:0] user_data,
    input logic [LANES*WIDTH-1:0] tx_data,
    input logic [2*LANES-1:0]     lane_delay,
    input logic                   busy,
    input logic                   done,
    input logic                   fail
);
    // R6 R7: lock and fail never coexist, and a search reports neither
    p_lock_fail_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fail));
    p_busy_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !(done || fail));
    p_fail_from_search_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fail) |-> $past(busy));
    // R9: a start outside a search opens a new one
    p_start_opens_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);
    // R10: settings frozen while locked
    p_hold_locked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(done)) |-> $stable(lane_delay));
    // R4: every step of the search moves the lane 0 digit
    p_step_lane0_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !$stable(lane_delay))
            |-> (lane_delay[1:0] != $past(lane_delay[1:0])));

    for (genvar g = 0; g < LANES; g++) begin : g_chk
        // R2: legal code and word delay per lane
        p_code_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
            lane_delay[2*g +: 2] != 2'd3);
        p_bypass_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (done && lane_delay[2*g +: 2] == 2'd0)
                |-> tx_data[g*WIDTH +: WIDTH] == user_data[g*WIDTH +: WIDTH]);
        p_one_stage_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (done && $past(done) && lane_delay[2*g +: 2] == 2'd1)
                |-> tx_data[g*WIDTH +: WIDTH] == $past(user_data[g*WIDTH +: WIDTH]));
    end
endmodule

bind tx_deskew_cal tx_deskew_cal_chk #(.LANES(LANES), .WIDTH(WIDTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .user_data  (user_data),
    .tx_data    (tx_data),
    .lane_delay (lane_delay),
    .busy       (busy),
    .done       (done),
    .fail       (fail)
);

// File: tb/test_tx_deskew_cal.sv
module test_tx_deskew_cal;
    localparam int LANES  = 4;
    localparam int WIDTH  = 32;
    localparam int SW     = 8;
    localparam int SETTLE = 4;
    localparam int HDEP   = 4;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   start = 1'b0;
    logic [SW-1:0]          settle_cycles = SW'(SETTLE);
    logic [LANES*WIDTH-1:0] user_data = '0;
    logic [LANES-1:0]       lane_aligned = '0;
    logic [LANES*WIDTH-1:0] tx_data;
    logic [2*LANES-1:0]     lane_delay;
    logic                   busy, done, fail;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    tx_deskew_cal #(.LANES(LANES), .WIDTH(WIDTH), .SETTLE_W(SW)) i_tx_deskew_cal (
        .clk(clk), .rst_n(rst_n), .start(start), .settle_cycles(settle_cycles),
        .user_data(user_data), .lane_aligned(lane_aligned), .tx_data(tx_data),
        .lane_delay(lane_delay), .busy(busy), .done(done), .fail(fail)
    );

    typedef struct {
        bit                 lock;
        logic [2*LANES-1:0] del;
        int                 cyc;
    } exp_t;
    exp_t exp_q[$];

    task automatic chk(input bit ok, input string req, input longint act, input longint expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // far end: lane i sees the transmitted word skew[i] cycles late
    int skew [LANES];
    logic [LANES*WIDTH-1:0] hist [HDEP];
    always @(negedge clk) begin
        for (int k = HDEP-1; k > 0; k--) hist[k] = hist[k-1];
        hist[0] = tx_data;
        for (int i = 0; i < LANES; i++)
            lane_aligned[i] = (hist[skew[i]][i*WIDTH +: WIDTH] == hist[skew[0]][WIDTH-1:0]);
    end

    // monitor: busy length, training word and lock/fail results
    int busy_len = 0;
    bit prev_busy = 0, prev_done = 0, prev_fail = 0, tr_valid = 0;
    logic [WIDTH-1:0] tr_prev;
    int n_results = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (busy && !prev_busy) begin
                busy_len = 1;
                chk(!done && !fail, "R9 flags cleared on restart", {done, fail}, 0);
            end else if (busy) busy_len++;
            if (busy && lane_delay == '0) begin
                for (int i = 1; i < LANES; i++)
                    chk(tx_data[i*WIDTH +: WIDTH] == tx_data[WIDTH-1:0], "R3 lanes share word",
                        tx_data[i*WIDTH +: WIDTH], tx_data[WIDTH-1:0]);
                if (tr_valid)
                    chk(tx_data[WIDTH-1:0] == tr_prev + 1, "R3 word steps by one",
                        tx_data[WIDTH-1:0], tr_prev + 1);
                tr_prev  = tx_data[WIDTH-1:0];
                tr_valid = 1;
            end else tr_valid = 0;
            if ((done && !prev_done) || (fail && !prev_fail)) begin
                exp_t e;
                n_results++;
                if (exp_q.size() == 0) chk(0, "R6 unexpected result", 1, 0);
                else begin
                    e = exp_q.pop_front();
                    chk(done == e.lock, e.lock ? "R6 lock reached" : "R7 fail reached", done, e.lock);
                    chk(!busy, "R6 busy low at result", busy, 0);
                    chk(lane_delay == e.del, e.lock ? "R4 R6 locked setting" : "R7 setting cleared",
                        lane_delay, e.del);
                    chk(busy_len == e.cyc, "R5 busy length", busy_len, e.cyc);
                end
            end
            prev_busy = busy; prev_done = done; prev_fail = fail;
        end
    end

    function automatic exp_t predict(input int s [LANES]);
        exp_t e;
        int ncomb = 1;
        for (int i = 0; i < LANES; i++) ncomb *= 3;
        e.lock = 0; e.del = '0; e.cyc = ncomb * (SETTLE + 1);
        for (int idx = 0; idx < ncomb; idx++) begin
            int v = idx;
            int d [LANES];
            bit good = 1;
            for (int i = 0; i < LANES; i++) begin d[i] = v % 3; v = v / 3; end
            for (int i = 1; i < LANES; i++) if (d[i] + s[i] != d[0] + s[0]) good = 0;
            if (good) begin
                e.lock = 1; e.cyc = (idx + 1) * (SETTLE + 1);
                for (int i = 0; i < LANES; i++) e.del[2*i +: 2] = 2'(d[i]);
                return e;
            end
        end
        return e;
    endfunction

    task automatic run_cal(input int s [LANES], input int extra_starts);
        exp_t e;
        int seen;
        for (int i = 0; i < LANES; i++) skew[i] = s[i];
        e = predict(s);
        exp_q.push_back(e);
        seen = n_results;
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
        for (int k = 0; k < extra_starts; k++) begin   // R8: ignored pulses
            repeat (3) @(negedge clk);
            start = 1;
            @(negedge clk); start = 0;
        end
        while (n_results == seen) @(negedge clk);
        if (e.lock) begin
            logic [LANES*WIDTH-1:0] uh [3];
            for (int k = 0; k < 3; k++) uh[k] = '0;
            for (int j = 0; j < 20; j++) begin
                @(negedge clk);
                for (int i = 0; i < LANES; i++) user_data[i*WIDTH +: WIDTH] = $urandom;
                uh[2] = uh[1]; uh[1] = uh[0]; uh[0] = user_data;
                #1;
                if (j >= 3)
                    for (int i = 0; i < LANES; i++) begin
                        int d = int'(e.del[2*i +: 2]);
                        chk(tx_data[i*WIDTH +: WIDTH] == uh[d][i*WIDTH +: WIDTH],
                            "R2 R6 user word through delay",
                            tx_data[i*WIDTH +: WIDTH], uh[d][i*WIDTH +: WIDTH]);
                    end
                chk(lane_delay == e.del, "R10 setting held", lane_delay, e.del);
            end
            @(negedge clk); user_data = '0;
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        for (int k = 0; k < HDEP; k++) hist[k] = '0;
        for (int i = 0; i < LANES; i++) skew[i] = 0;
        repeat (3) @(negedge clk);
        chk(!busy && !done && !fail, "R1 flags after reset", {busy, done, fail}, 0);
        chk(lane_delay == '0, "R1 delay after reset", lane_delay, 0);
        rst_n = 1;
        @(negedge clk);
        chk(!busy && !done && !fail, "R1 idle after release", {busy, done, fail}, 0);
        run_cal('{0, 0, 0, 0}, 0);   // R6 first combination aligns
        run_cal('{2, 1, 0, 1}, 2);   // R4 R8 deeper search with ignored starts
        run_cal('{1, 0, 1, 0}, 0);   // R9 restart from locked
        run_cal('{0, 3, 0, 0}, 0);   // R7 unreachable skew
        repeat (2) @(negedge clk);
        chk(!busy && fail && lane_delay == '0, "R7 idle after fail", {busy, fail, lane_delay}, 1);
        run_cal('{0, 0, 0, 0}, 0);   // R9 restart from fail
        summary();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
    end
endmodule